// File: doc/BRIEF.md
# Prescaled PWM Generator with Pulse-Width Capture

This block is a single pulse-width channel. A two-stage divider turns the bus clock into a counting tick. A 32-bit counter runs on that tick. In the waveform modes, the counter compares against a programmed period and duty to drive an output pin. The pin can run for a fixed number of periods, run until software stops it, or be held quiet while the counter keeps time. In capture mode the same counter measures an external input: it records how long the input stayed low and how long it stayed high, and restarts on every edge.

Software reaches the channel through a synchronous write port and a combinational read port, eight word addresses wide. Period and duty live in shadow copies that are reloaded only at a period boundary, so a reprogrammed waveform never produces a runt pulse. A sticky interrupt line reports finished work: the end of each period in the free-running and quiet modes, the end of a burst in one-shot mode, and every input edge in capture mode.

Top module: `pwm_capture_unit`

## Requirements
- R1: After reset, `pwm_out` and `irq` are 0 and every register (CTRL, SCALER, PERIOD, DUTY, STATUS, COUNT) reads 0.
- R2: SCALER holds the first divide value `pre` in bits [7:0] and the second `scl` in bits [15:8]. The counter advances once every (pre+1)*(scl+1) clock cycles. With both at 0 it advances every cycle.
- R3: The CTRL bits are run in bit 0, mode in bits [2:1], invert in bit 3 and the burst repeat count in bits [15:8]. Mode 1 is continuous. With run=1 the output is active while the counter is below DUTY and inactive for the rest of PERIOD ticks, and this repeats until run is cleared. The counter wraps to 0 after PERIOD-1.
- R4: A DUTY of 0 keeps the output inactive for the whole period. A DUTY equal to or above PERIOD keeps it active for the whole period.
- R5: A PERIOD or DUTY write made while running takes effect only from the next period boundary. The period in progress completes with the old values.
- R6: Mode 0 is one-shot. The channel emits repeat+1 periods, then clears the run bit, returns the output to inactive and raises the interrupt. No interrupt is raised at the earlier period ends.
- R7: The invert bit flips the output. The inactive level is 1 when invert=1, and this holds also while stopped.
- R8: Mode 2 is reference. The output stays at the inactive level while the counter keeps counting (readable at COUNT) and wraps at PERIOD. Each wrap raises the interrupt.
- R9: Mode 3 is capture. The input passes through a two-flop synchronizer. On each rising edge the number of ticks since the previous edge goes to CAP_LO (address 4). On each falling edge that number goes to CAP_HI (address 5). The counter restarts from 0 at every edge, and the output stays inactive.
- R10: The interrupt is sticky and shows in STATUS bit 0. Writing 1 to STATUS bit 0 clears it. When a clear and a new event fall in the same cycle, the interrupt stays set.
- R11: In capture mode every detected input edge raises the interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, sampled on the rising clock edge |
| wr_addr | input | 3 | Write word address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read word address |
| rd_data | output | 32 | Read data for `rd_addr`, combinational |
| cap_in | input | 1 | Asynchronous signal measured in capture mode |
| pwm_out | output | 1 | Waveform output |
| irq | output | 1 | Sticky interrupt request |

## Verification
Two things can happen in the same cycle: the hardware sets the interrupt at a period wrap, and software writes the STATUS clear. The bench provokes this in continuous mode with a four-tick period. It counts cycles from the enabling write so that the clear lands exactly on the edge where the second wrap occurs. The bench judges the result by reading `irq` just after that edge: it must still be 1. A second clear one cycle later, when no event occurs, must bring it to 0. The shadow reload is judged the same way: a period and duty rewrite is placed mid-period, and the output trace must keep the old shape up to the wrap edge and take the new shape from that edge on.

// File: rtl/pwmc_pkg.sv
package pwmc_pkg;
  parameter int CNT_W  = 32;
  parameter int ADDR_W = 3;

  typedef enum logic [1:0] {
    MODE_ONESHOT = 2'd0,
    MODE_CONT    = 2'd1,
    MODE_REF     = 2'd2,
    MODE_CAP     = 2'd3
  } pwmc_mode_e;

  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_SCALE  = 3'd1;
  localparam logic [ADDR_W-1:0] A_PERIOD = 3'd2;
  localparam logic [ADDR_W-1:0] A_DUTY   = 3'd3;
  localparam logic [ADDR_W-1:0] A_CAPLO  = 3'd4;
  localparam logic [ADDR_W-1:0] A_CAPHI  = 3'd5;
  localparam logic [ADDR_W-1:0] A_STAT   = 3'd6;
  localparam logic [ADDR_W-1:0] A_COUNT  = 3'd7;

  // last tick of a period; periods of 0 or 1 end on every tick
  function automatic logic period_done(input logic [CNT_W-1:0] cnt,
                                       input logic [CNT_W-1:0] per);
    if (per <= CNT_W'(1)) return 1'b1;
    return cnt >= (per - CNT_W'(1));
  endfunction

  // active phase of the waveform
  function automatic logic drive_level(input logic [CNT_W-1:0] cnt,
                                       input logic [CNT_W-1:0] duty);
    return cnt < duty;
  endfunction

  // ticks elapsed since the previous edge, counting the current cycle's tick
  function automatic logic [CNT_W-1:0] span_value(input logic [CNT_W-1:0] cnt,
                                                  input logic tick);
    return cnt + {{(CNT_W-1){1'b0}}, tick};
  endfunction
endpackage

// File: rtl/pwmc_sync.sv
module pwmc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pwmc_prescaler.sv
module pwmc_prescaler #(
  parameter int PRE_W = 8,
  parameter int SCL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PRE_W-1:0] pre,
  input  logic [SCL_W-1:0] scl,
  output logic             tick
);
  logic [PRE_W-1:0] pre_cnt;
  logic [SCL_W-1:0] scl_cnt;
  logic             stage1;

  assign stage1 = run && (pre_cnt >= pre);
  assign tick   = stage1 && (scl_cnt >= scl);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      scl_cnt <= '0;
    end else if (!run) begin
      pre_cnt <= '0;
      scl_cnt <= '0;
    end else begin
      pre_cnt <= stage1 ? '0 : pre_cnt + 1'b1;
      if (stage1) scl_cnt <= tick ? '0 : scl_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pwmc_core.sv
module pwmc_core
  import pwmc_pkg::*;
#(
  parameter int RPT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  pwmc_mode_e       mode,
  input  logic             invert,
  input  logic [RPT_W-1:0] rpt,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] duty,
  input  logic             tick,
  input  logic             cap_lvl,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cap_lo,
  output logic [CNT_W-1:0] cap_hi,
  output logic             pwm_out,
  output logic             period_wrap,
  output logic             stop_evt,
  output logic             cap_evt
);
  logic [CNT_W-1:0] per_act;
  logic [CNT_W-1:0] duty_act;
  logic [RPT_W-1:0] done_cnt;
  logic             cap_prev;
  logic             cap_rise;
  logic             cap_fall;
  logic             wave_mode;
  logic             active;

  assign wave_mode   = (mode != MODE_CAP);
  assign period_wrap = run && wave_mode && tick && period_done(cnt, per_act);
  assign stop_evt    = period_wrap && (mode == MODE_ONESHOT) && (done_cnt == rpt);
  assign cap_rise    = run && (mode == MODE_CAP) && cap_lvl && !cap_prev;
  assign cap_fall    = run && (mode == MODE_CAP) && !cap_lvl && cap_prev;
  assign cap_evt     = cap_rise || cap_fall;

  assign active  = run && (mode == MODE_ONESHOT || mode == MODE_CONT) &&
                   drive_level(cnt, duty_act);
  assign pwm_out = active ^ invert;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      per_act  <= '0;
      duty_act <= '0;
      done_cnt <= '0;
      cap_prev <= 1'b0;
      cap_lo   <= '0;
      cap_hi   <= '0;
    end else begin
      cap_prev <= cap_lvl;
      if (!run) begin
        cnt      <= '0;
        per_act  <= period;
        duty_act <= duty;
        done_cnt <= '0;
      end else if (wave_mode) begin
        if (period_wrap) begin
          cnt      <= '0;
          per_act  <= period;
          duty_act <= duty;
          if (mode == MODE_ONESHOT) done_cnt <= done_cnt + 1'b1;
        end else if (tick) begin
          cnt <= cnt + 1'b1;
        end
      end else begin
        if (cap_rise) begin
          cap_lo <= span_value(cnt, tick);
          cnt    <= '0;
        end else if (cap_fall) begin
          cap_hi <= span_value(cnt, tick);
          cnt    <= '0;
        end else if (tick) begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R3
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && wave_mode && per_act > CNT_W'(1)) |-> (cnt < per_act));

  // R5
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run) && run && !$past(period_wrap)) |->
      (per_act == $past(per_act) && duty_act == $past(duty_act)));

  // R8
  ref_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && mode == MODE_REF) |-> (pwm_out == invert));
endmodule

// File: rtl/pwm_capture_unit.sv
module pwm_capture_unit
  import pwmc_pkg::*;
#(
  parameter int PRE_W       = 8,
  parameter int SCL_W       = 8,
  parameter int RPT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data,
  input  logic              cap_in,
  output logic              pwm_out,
  output logic              irq
);
  localparam int RPT_LSB = 8;
  localparam int RPT_MSB = RPT_LSB + RPT_W - 1;
  localparam int SCL_LSB = PRE_W;
  localparam int SCL_MSB = PRE_W + SCL_W - 1;

  logic             run_q;
  pwmc_mode_e       mode_q;
  logic             inv_q;
  logic [RPT_W-1:0] rpt_q;
  logic [PRE_W-1:0] pre_q;
  logic [SCL_W-1:0] scl_q;
  logic [CNT_W-1:0] period_q;
  logic [CNT_W-1:0] duty_q;
  logic             irq_q;

  logic             ctrl_wr;
  logic             irq_clr;
  logic             irq_set;
  logic             tick;
  logic             cap_lvl;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cap_lo;
  logic [CNT_W-1:0] cap_hi;
  logic             period_wrap;
  logic             stop_evt;
  logic             cap_evt;

  assign ctrl_wr = wr_en && (wr_addr == A_CTRL);
  assign irq_clr = wr_en && (wr_addr == A_STAT) && wr_data[0];
  assign irq_set = (period_wrap && (mode_q == MODE_CONT || mode_q == MODE_REF)) ||
                   stop_evt || cap_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      mode_q   <= MODE_ONESHOT;
      inv_q    <= 1'b0;
      rpt_q    <= '0;
      pre_q    <= '0;
      scl_q    <= '0;
      period_q <= '0;
      duty_q   <= '0;
    end else begin
      if (ctrl_wr) begin
        run_q  <= wr_data[0];
        mode_q <= pwmc_mode_e'(wr_data[2:1]);
        inv_q  <= wr_data[3];
        rpt_q  <= wr_data[RPT_MSB:RPT_LSB];
      end else if (stop_evt) begin
        run_q <= 1'b0;
      end
      if (wr_en && wr_addr == A_SCALE) begin
        pre_q <= wr_data[PRE_W-1:0];
        scl_q <= wr_data[SCL_MSB:SCL_LSB];
      end
      if (wr_en && wr_addr == A_PERIOD) period_q <= wr_data;
      if (wr_en && wr_addr == A_DUTY)   duty_q   <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       irq_q <= 1'b0;
    else if (irq_set) irq_q <= 1'b1;
    else if (irq_clr) irq_q <= 1'b0;
  end
  assign irq = irq_q;

  generate
    if (SYNC_STAGES > 0) begin : g_sync
      pwmc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(cap_in), .q(cap_lvl));
    end else begin : g_nosync
      assign cap_lvl = cap_in;
    end
  endgenerate

  pwmc_prescaler #(.PRE_W(PRE_W), .SCL_W(SCL_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run_q), .pre(pre_q), .scl(scl_q), .tick(tick));

  pwmc_core #(.RPT_W(RPT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .run(run_q), .mode(mode_q), .invert(inv_q),
    .rpt(rpt_q), .period(period_q), .duty(duty_q), .tick(tick),
    .cap_lvl(cap_lvl), .cnt(cnt), .cap_lo(cap_lo), .cap_hi(cap_hi),
    .pwm_out(pwm_out), .period_wrap(period_wrap), .stop_evt(stop_evt),
    .cap_evt(cap_evt));

  always_comb begin
    case (rd_addr)
      A_CTRL:   rd_data = CNT_W'({rpt_q, 4'b0000, inv_q, mode_q, run_q});
      A_SCALE:  rd_data = CNT_W'({scl_q, pre_q});
      A_PERIOD: rd_data = period_q;
      A_DUTY:   rd_data = duty_q;
      A_CAPLO:  rd_data = cap_lo;
      A_CAPHI:  rd_data = cap_hi;
      A_STAT:   rd_data = CNT_W'(irq_q);
      default:  rd_data = cnt;
    endcase
  end

  // R10
  irq_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_set |=> irq);

  // R3
  wrap_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (period_wrap && mode_q == MODE_CONT) |=> irq);

  // R6
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_evt && !ctrl_wr) |=> (!run_q && irq));

  // R11
  cap_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> irq);
endmodule

// File: tb/pwm_capture_unit_bench.sv
module pwm_capture_unit_bench;
  localparam logic [2:0] R_CTRL = 3'd0, R_SCALE = 3'd1, R_PER = 3'd2, R_DUTY = 3'd3,
                         R_CLO = 3'd4, R_CHI = 3'd5, R_STAT = 3'd6, R_CNT = 3'd7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        cap_in = 1'b0;
  logic        pwm_out;
  logic        irq;

  int errors = 0;
  int checks = 0;
  bit    exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  pwm_capture_unit u_pwm_capture_unit (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .cap_in(cap_in), .pwm_out(pwm_out), .irq(irq));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // called at a negedge; the write lands on the next rising edge
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string req);
    rd_addr = a;
    #1;
    check(req, rd_data, exp);
  endtask

  task automatic push(input bit v, input string req);
    exp_q.push_back(v);
    tag_q.push_back(req);
  endtask

  task automatic drain();
    wait (exp_q.size() == 0);
    @(negedge clk);
  endtask

  // monitor: one expected output level per cycle, sampled just after the edge
  initial begin
    bit    e;
    string r;
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        r = tag_q.pop_front();
        check(r, {31'b0, pwm_out}, {31'b0, e});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 pwm_out", {31'b0, pwm_out}, 32'd0);
    check("R1 irq", {31'b0, irq}, 32'd0);
    rd(R_CTRL, 0, "R1 ctrl");
    rd(R_SCALE, 0, "R1 scaler");
    rd(R_PER, 0, "R1 period");
    rd(R_DUTY, 0, "R1 duty");
    rd(R_STAT, 0, "R1 status");
    rd(R_CNT, 0, "R1 count");
    @(negedge clk);

    // R3 continuous, period 5 duty 2
    wr(R_PER, 5); wr(R_DUTY, 2);
    for (int j = 0; j < 15; j++) push((j % 5) < 2, "R3 continuous");
    wr(R_CTRL, 32'h3);
    drain();
    check("R3 irq after wraps", {31'b0, irq}, 32'd1);
    wr(R_CTRL, 0);
    check("R3 idle output", {31'b0, pwm_out}, 32'd0);
    rd(R_STAT, 1, "R10 sticky");
    @(negedge clk);
    wr(R_STAT, 1);
    check("R10 cleared", {31'b0, irq}, 32'd0);

    // R4 duty extremes
    wr(R_PER, 4); wr(R_DUTY, 0);
    for (int j = 0; j < 8; j++) push(1'b0, "R4 duty zero");
    wr(R_CTRL, 32'h3);
    drain();
    wr(R_CTRL, 0);
    wr(R_DUTY, 7);
    for (int j = 0; j < 8; j++) push(1'b1, "R4 duty above period");
    wr(R_CTRL, 32'h3);
    drain();
    wr(R_CTRL, 0);

    // R5 reload only at the boundary: 4/1 then 6/3 written mid-period
    wr(R_PER, 4); wr(R_DUTY, 1);
    for (int j = 0; j < 8; j++) push((j % 4) < 1, "R5 old shape");
    for (int j = 0; j < 12; j++) push((j % 6) < 3, "R5 new shape");
    wr(R_CTRL, 32'h3);
    repeat (4) @(negedge clk);
    wr(R_PER, 6);
    wr(R_DUTY, 3);
    drain();
    wr(R_CTRL, 0);

    // R7 inverted output
    wr(R_PER, 3); wr(R_DUTY, 1);
    wr(R_CTRL, 32'h8);
    check("R7 idle inverted", {31'b0, pwm_out}, 32'd1);
    for (int j = 0; j < 9; j++) push(!((j % 3) < 1), "R7 inverted wave");
    wr(R_CTRL, 32'hB);
    drain();
    wr(R_CTRL, 0);
    check("R7 back to normal", {31'b0, pwm_out}, 32'd0);

    // R6 one-shot, two periods of 3 with duty 2
    wr(R_STAT, 1);
    wr(R_PER, 3); wr(R_DUTY, 2);
    for (int j = 0; j < 9; j++) push((j < 6) && ((j % 3) < 2), "R6 burst");
    wr(R_CTRL, 32'h101);
    repeat (4) @(negedge clk);
    check("R6 no irq mid burst", {31'b0, irq}, 32'd0);
    drain();
    rd(R_CTRL, 32'h100, "R6 run cleared");
    check("R6 irq at end", {31'b0, irq}, 32'd1);
    @(negedge clk);
    wr(R_STAT, 1);
    wr(R_PER, 2); wr(R_DUTY, 1);
    push(1'b1, "R6 single"); push(1'b0, "R6 single");
    push(1'b0, "R6 single"); push(1'b0, "R6 single");
    wr(R_CTRL, 32'h1);
    drain();
    check("R6 single irq", {31'b0, irq}, 32'd1);

    // R8 reference mode
    wr(R_STAT, 1);
    wr(R_PER, 4); wr(R_DUTY, 2);
    for (int j = 0; j < 8; j++) push(1'b0, "R8 quiet output");
    wr(R_CTRL, 32'h5);
    repeat (2) @(negedge clk);
    rd(R_CNT, 2, "R8 counter runs");
    drain();
    check("R8 irq on wrap", {31'b0, irq}, 32'd1);
    wr(R_CTRL, 0);

    // R2 prescaler 2x3 = 6 cycles per tick, period 2 duty 1
    wr(R_SCALE, 32'h201);
    rd(R_SCALE, 32'h201, "R2 scaler fields");
    @(negedge clk);
    wr(R_PER, 2); wr(R_DUTY, 1);
    for (int j = 0; j < 24; j++) push(((j / 6) % 2) == 0, "R2 prescaled wave");
    wr(R_CTRL, 32'h3);
    drain();
    wr(R_CTRL, 0);
    wr(R_SCALE, 0);

    // R9 / R11 capture: 7 cycles high, 4 cycles low
    wr(R_STAT, 1);
    wr(R_CTRL, 32'h7);
    check("R9 output quiet", {31'b0, pwm_out}, 32'd0);
    repeat (3) @(negedge clk);
    cap_in = 1'b1;
    repeat (7) @(negedge clk);
    cap_in = 1'b0;
    repeat (4) @(negedge clk);
    rd(R_CNT, 1, "R9 restart on edge");
    cap_in = 1'b1;
    repeat (4) @(negedge clk);
    rd(R_CHI, 7, "R9 high time");
    rd(R_CLO, 4, "R9 low time");
    check("R11 edge irq", {31'b0, irq}, 32'd1);
    @(negedge clk);
    wr(R_STAT, 1);
    check("R11 cleared while stable", {31'b0, irq}, 32'd0);
    cap_in = 1'b0;
    repeat (4) @(negedge clk);
    check("R11 falling edge irq", {31'b0, irq}, 32'd1);
    wr(R_CTRL, 0);

    // R10 clear coinciding with a wrap: period 4, second wrap at edge E+8
    wr(R_STAT, 1);
    wr(R_PER, 4); wr(R_DUTY, 2);
    wr(R_CTRL, 32'h3);
    repeat (7) @(negedge clk);
    wr(R_STAT, 1);
    check("R10 set wins over clear", {31'b0, irq}, 32'd1);
    wr(R_STAT, 1);
    check("R10 clear alone", {31'b0, irq}, 32'd0);
    wr(R_CTRL, 0);

    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule